// File: doc/BRIEF.md
# DRAM Single-Bank Row-Buffer Controller

This block drives one DRAM bank for a stream of read requests, each carrying a row and a column. It remembers whether the bank's single row buffer is empty or holds a row, and which row. Each request is classified as a hit, an empty-bank access or a row conflict. The block then emits the matching sequence of precharge, activate and read commands, each phase taking a fixed number of cycles. One cycle stands for 10 ns. The default latencies of two cycles per phase therefore give 20, 40 and 60 ns for the three cases.

A policy input selects between two page policies. In open-page mode the row stays latched after a read. In close-page mode the bank is precharged in the same cycle that a read completes, so the precharge overlaps idle time. Requests are served strictly in arrival order, one at a time. A request that arrives while the bank is busy waits in a short queue and starts at the previous completion time. When each read completes, the block raises a one-cycle pulse that reports the classification, the request's row and column, and the cycle count since reset.

Top module: `rowbuf_ctrl`

## Requirements
- R1: After reset the bank is empty and no command or completion is produced until a request arrives. The first read request is classified as an empty-bank access.
- R2: An empty-bank access issues ACT (cmd_op=2) in its start cycle and RD (cmd_op=3) T_RCD cycles later. It completes T_RCD+T_CL cycles after the start, with done_kind=1.
- R3: A request to the row currently held open issues only RD in its start cycle and completes T_CL cycles later, with done_kind=0.
- R4: A request to a different row than the open one issues PRE (cmd_op=1), then ACT T_RP cycles later, then RD T_RCD cycles after that. It completes T_RP+T_RCD+T_CL cycles after the start, with done_kind=2.
- R5: With close_page=0, the row stays open after a completion, and no command is issued while no request is pending.
- R6: With close_page=1, a PRE is issued in the same cycle as each completion pulse.
- R7: With close_page=1, a request that arrives during that automatic precharge waits until T_RP cycles after the completion, then issues ACT.
- R8: A request that arrives while an earlier one is in service starts in the cycle in which the earlier one completes.
- R9: Completions appear in the same order as the requests arrived.
- R10: The queue holds Q_DEPTH waiting requests. A request that arrives when the queue is full and no entry leaves in that cycle is discarded and never completes.
- R11: done_time equals the number of cycles since reset was released (0 in the first cycle). At most one command is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle = 10 ns of DRAM time |
| rst | input | 1 | Synchronous active-high reset |
| close_page | input | 1 | 1 = close-page policy, 0 = open-page policy |
| req_valid | input | 1 | A read request arrives this cycle |
| req_row | input | ROW_W | Row of the arriving request |
| req_col | input | COL_W | Column of the arriving request |
| cmd_op | output | 2 | Bank command this cycle: 0 none, 1 PRE, 2 ACT, 3 RD |
| cmd_row | output | ROW_W | Row for ACT/PRE/RD |
| cmd_col | output | COL_W | Column for RD |
| done | output | 1 | One-cycle completion pulse |
| done_kind | output | 2 | 0 hit, 1 empty bank, 2 conflict |
| done_row | output | ROW_W | Row of the completed request |
| done_col | output | COL_W | Column of the completed request |
| done_time | output | TIME_W | Completion time in cycles since reset |

## Verification
The bench replays a six-request stream over two rows under both policies and compares every completion cycle and classification with values computed from the latency sums. The timing corner cases are a conflict arriving mid-service, a hit right after a conflict, and requests that land inside the automatic precharge window. A design that starts queued work at arrival time instead of at the previous completion would finish those requests early. A design that skips the remaining precharge would activate while the bitlines are still recovering. A design that precharges eagerly in open-page mode would misreport the later hit as an empty-bank access. A burst that overfills the queue checks that the excess request never completes and that the served ones keep their order.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_ACT = 2'd2,
        CMD_RD  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ACC_HIT      = 2'd0,
        ACC_EMPTY    = 2'd1,
        ACC_CONFLICT = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_ACT,
        PH_COL,
        PH_AUTO
    } phase_e;

    function automatic acc_e classify(input logic is_open, input logic same_row);
        if (!is_open)      return ACC_EMPTY;
        else if (same_row) return ACC_HIT;
        else               return ACC_CONFLICT;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rbc_timebase.sv
module rbc_timebase #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [TIME_W-1:0] now
);
    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + 1'b1;
    end
endmodule

// File: rtl/rbc_queue.sv
module rbc_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         take,
    output logic         head_valid,
    output logic [W-1:0] head_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          stored, bypass, pop, push;

    assign stored     = (count != '0);
    assign head_valid = stored || in_valid;
    assign head_data  = stored ? slots[rd_ptr] : in_data;
    assign bypass     = !stored && in_valid && take;
    assign pop        = stored && take;
    assign push       = in_valid && !bypass && ((count != FULL) || pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= in_data;
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rbc_sequencer.sv
module rbc_sequencer
    import rbc_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int T_RP  = 2,
    parameter int T_RCD = 2,
    parameter int T_CL  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             close_page,
    input  logic             head_valid,
    input  logic [ROW_W-1:0] head_row,
    input  logic [COL_W-1:0] head_col,
    output logic             take,
    output cmd_e             cmd_op,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             done,
    output acc_e             done_kind,
    output logic [ROW_W-1:0] done_row,
    output logic [COL_W-1:0] done_col
);
    localparam int MAXL = max3(T_RP, T_RCD, T_CL);
    localparam int TW   = $clog2(MAXL + 1);
    localparam logic [TW-1:0] L_RP  = TW'(T_RP - 1);
    localparam logic [TW-1:0] L_RCD = TW'(T_RCD - 1);
    localparam logic [TW-1:0] L_CL  = TW'(T_CL - 1);

    phase_e           phase, nxt_phase;
    logic [TW-1:0]    tmr, nxt_tmr;
    logic             open_q;
    logic [ROW_W-1:0] open_row;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;
    acc_e             cur_kind, new_kind;
    logic             expire, free;

    assign expire    = (phase != PH_IDLE) && (tmr == '0);
    assign new_kind  = classify(open_q, open_row == head_row);
    assign done_kind = cur_kind;
    assign done_row  = cur_row;
    assign done_col  = cur_col;

    always_comb begin
        cmd_op    = CMD_NOP;
        cmd_row   = cur_row;
        cmd_col   = cur_col;
        done      = 1'b0;
        take      = 1'b0;
        free      = 1'b0;
        nxt_phase = phase;
        nxt_tmr   = (tmr != '0) ? tmr - 1'b1 : tmr;
        case (phase)
            PH_IDLE: free = 1'b1;
            PH_PRE: if (expire) begin
                cmd_op    = CMD_ACT;
                nxt_phase = PH_ACT;
                nxt_tmr   = L_RCD;
            end
            PH_ACT: if (expire) begin
                cmd_op    = CMD_RD;
                nxt_phase = PH_COL;
                nxt_tmr   = L_CL;
            end
            PH_COL: if (expire) begin
                done = 1'b1;
                if (close_page) begin
                    cmd_op    = CMD_PRE;
                    nxt_phase = PH_AUTO;
                    nxt_tmr   = L_RP;
                end else begin
                    free = 1'b1;
                end
            end
            PH_AUTO: if (expire) free = 1'b1;
            default: nxt_phase = PH_IDLE;
        endcase
        if (free) begin
            if (head_valid) begin
                take    = 1'b1;
                cmd_row = head_row;
                cmd_col = head_col;
                case (new_kind)
                    ACC_HIT: begin
                        cmd_op    = CMD_RD;
                        nxt_phase = PH_COL;
                        nxt_tmr   = L_CL;
                    end
                    ACC_EMPTY: begin
                        cmd_op    = CMD_ACT;
                        nxt_phase = PH_ACT;
                        nxt_tmr   = L_RCD;
                    end
                    default: begin
                        cmd_op    = CMD_PRE;
                        cmd_row   = open_row;
                        nxt_phase = PH_PRE;
                        nxt_tmr   = L_RP;
                    end
                endcase
            end else begin
                nxt_phase = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            tmr      <= '0;
            open_q   <= 1'b0;
            open_row <= '0;
            cur_row  <= '0;
            cur_col  <= '0;
            cur_kind <= ACC_EMPTY;
        end else begin
            phase <= nxt_phase;
            tmr   <= nxt_tmr;
            if (take) begin
                cur_row  <= head_row;
                cur_col  <= head_col;
                cur_kind <= new_kind;
            end
            if (cmd_op == CMD_PRE) open_q <= 1'b0;
            else if (cmd_op == CMD_ACT) begin
                open_q   <= 1'b1;
                open_row <= cmd_row;
            end
        end
    end
endmodule

// File: rtl/rowbuf_ctrl.sv
module rowbuf_ctrl
    import rbc_pkg::*;
#(
    parameter int ROW_W   = 4,
    parameter int COL_W   = 4,
    parameter int T_RP    = 2,
    parameter int T_RCD   = 2,
    parameter int T_CL    = 2,
    parameter int Q_DEPTH = 4,
    parameter int TIME_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              close_page,
    input  logic              req_valid,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic [1:0]        cmd_op,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              done,
    output logic [1:0]        done_kind,
    output logic [ROW_W-1:0]  done_row,
    output logic [COL_W-1:0]  done_col,
    output logic [TIME_W-1:0] done_time
);
    localparam int RW = ROW_W + COL_W;

    logic             head_valid, take;
    logic [RW-1:0]    head_data;
    cmd_e             seq_cmd;
    acc_e             seq_kind;
    logic [TIME_W-1:0] now;

    rbc_timebase #(.TIME_W(TIME_W)) u_time (
        .clk (clk),
        .rst (rst),
        .now (now)
    );

    rbc_queue #(.DEPTH(Q_DEPTH), .W(RW)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (req_valid),
        .in_data    ({req_row, req_col}),
        .take       (take),
        .head_valid (head_valid),
        .head_data  (head_data)
    );

    rbc_sequencer #(
        .ROW_W (ROW_W), .COL_W (COL_W),
        .T_RP  (T_RP),  .T_RCD (T_RCD), .T_CL (T_CL)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .close_page (close_page),
        .head_valid (head_valid),
        .head_row   (head_data[RW-1:COL_W]),
        .head_col   (head_data[COL_W-1:0]),
        .take       (take),
        .cmd_op     (seq_cmd),
        .cmd_row    (cmd_row),
        .cmd_col    (cmd_col),
        .done       (done),
        .done_kind  (seq_kind),
        .done_row   (done_row),
        .done_col   (done_col)
    );

    assign cmd_op    = seq_cmd;
    assign done_kind = seq_kind;
    assign done_time = now;
endmodule

// File: rtl/rbc_checker.sv
module rbc_checker
    import rbc_pkg::*;
#(
    parameter int T_RP  = 2,
    parameter int T_RCD = 2,
    parameter int T_CL  = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       close_page,
    input logic [1:0] cmd_op,
    input logic       done,
    input logic [1:0] done_kind
);
    localparam int MAXL = max3(T_RP, T_RCD, T_CL);
    localparam int CW   = $clog2(MAXL + 2);
    localparam logic [CW-1:0] SAT = CW'(MAXL + 1);

    logic          bank_open;
    logic [CW-1:0] since_pre, since_act, since_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_open <= 1'b0;
            since_pre <= SAT;
            since_act <= SAT;
            since_rd  <= SAT;
        end else begin
            if (cmd_op == CMD_PRE) bank_open <= 1'b0;
            if (cmd_op == CMD_ACT) bank_open <= 1'b1;
            since_pre <= (cmd_op == CMD_PRE) ? CW'(1) : ((since_pre != SAT) ? since_pre + 1'b1 : SAT);
            since_act <= (cmd_op == CMD_ACT) ? CW'(1) : ((since_act != SAT) ? since_act + 1'b1 : SAT);
            since_rd  <= (cmd_op == CMD_RD)  ? CW'(1) : ((since_rd  != SAT) ? since_rd  + 1'b1 : SAT);
        end
    end

    // R1 / R2: a read never reaches a bank without an activated row
    p_rd_needs_row_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == CMD_RD) |-> (bank_open && since_act >= CW'(T_RCD)));

    // R3: each completion lands exactly T_CL cycles after its read
    p_done_after_rd_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (since_rd == CW'(T_CL)));

    // R4: activate only on a closed bank, after the precharge time
    p_act_closed_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == CMD_ACT) |-> (!bank_open && since_pre >= CW'(T_RP)));

    // R6: close-page precharges in the completion cycle
    p_close_pre_r6: assert property (@(posedge clk) disable iff (rst)
        (done && close_page) |-> (cmd_op == CMD_PRE));

    // R11: classification code is always one of the three legal values
    p_kind_legal_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> (done_kind != 2'd3));
endmodule

bind rowbuf_ctrl rbc_checker #(
    .T_RP (T_RP), .T_RCD (T_RCD), .T_CL (T_CL)
) u_rbc_checker (
    .clk        (clk),
    .rst        (rst),
    .close_page (close_page),
    .cmd_op     (cmd_op),
    .done       (done),
    .done_kind  (done_kind)
);

// File: tb/test_rowbuf_ctrl.sv
module test_rowbuf_ctrl;
    localparam int ROW_W = 4;
    localparam int COL_W = 4;
    localparam int LOGN  = 128;
    localparam int MAXD  = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             close_page = 1'b0;
    logic             req_valid = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [1:0]       cmd_op;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;
    logic             done;
    logic [1:0]       done_kind;
    logic [ROW_W-1:0] done_row;
    logic [COL_W-1:0] done_col;
    logic [15:0]      done_time;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_done = 0;
    int log_op [LOGN];
    int log_row[LOGN];
    int d_cyc [MAXD];
    int d_kind[MAXD];
    int d_row [MAXD];
    int d_time[MAXD];
    bit finished = 1'b0;

    rowbuf_ctrl i_rowbuf_ctrl (
        .clk(clk), .rst(rst), .close_page(close_page),
        .req_valid(req_valid), .req_row(req_row), .req_col(req_col),
        .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .done(done), .done_kind(done_kind), .done_row(done_row),
        .done_col(done_col), .done_time(done_time)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        #5;
        if (rst) begin
            n_done = 0;
            for (int i = 0; i < LOGN; i++) begin
                log_op[i]  = 0;
                log_row[i] = 0;
            end
        end else begin
            if (cyc < LOGN) begin
                log_op[cyc]  = int'(cmd_op);
                log_row[cyc] = int'(cmd_row);
            end
            if (done && n_done < MAXD) begin
                d_cyc[n_done]  = cyc;
                d_kind[n_done] = int'(done_kind);
                d_row[n_done]  = int'(done_row);
                d_time[n_done] = int'(done_time);
                n_done = n_done + 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit pol);
        rst = 1'b1;
        close_page = pol;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        #6;
        chk("R1 no cmd in reset", int'(cmd_op), 0);
        chk("R1 no done in reset", int'(done), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic arrive(input int at, input int row, input int col);
        while (cyc < at) @(negedge clk);
        req_valid = 1'b1;
        req_row   = ROW_W'(row);
        req_col   = COL_W'(col);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_until(input int at);
        while (cyc < at) @(negedge clk);
        #8;
    endtask

    // X-series row 3, Y-series row 5, arrivals 0,1,10,20,25,30
    task automatic stream();
        arrive(0, 3, 0);
        arrive(1, 5, 0);
        arrive(10, 3, 1);
        arrive(20, 3, 2);
        arrive(25, 5, 1);
        arrive(30, 3, 3);
        run_until(60);
    endtask

    initial begin
        int exp_o[6] = '{4, 10, 16, 22, 31, 37};
        int kin_o[6] = '{1, 2, 2, 0, 2, 2};
        int exp_c[6] = '{4, 10, 16, 24, 30, 36};
        int rows[6]  = '{3, 5, 3, 3, 5, 3};

        // ---------- open page ----------
        do_reset(1'b0);
        stream();
        chk("R1 first is empty kind", d_kind[0], 1);
        chk("R2 ACT at start", log_op[0], 2);
        chk("R2 ACT row", log_row[0], 3);
        chk("R2 RD after T_RCD", log_op[2], 3);
        chk("R2 done cycle", d_cyc[0], 4);
        chk("R4 PRE at start", log_op[4], 1);
        chk("R4 ACT after T_RP", log_op[6], 2);
        chk("R4 ACT row", log_row[6], 5);
        chk("R4 RD", log_op[8], 3);
        chk("R8 busy arrival finishes from prior completion", d_cyc[1], 10);
        chk("R3 hit RD only", log_op[20], 3);
        chk("R3 no cmd after hit RD", log_op[21], 0);
        for (int k = 22; k < 25; k++) chk("R5 row held open, no cmd", log_op[k], 0);
        chk("R5 later conflict precharges", log_op[25], 1);
        chk("R9 open count", n_done, 6);
        for (int i = 0; i < 6; i++) begin
            chk("R8 open finish cycle", d_cyc[i], exp_o[i]);
            chk("R4 open kind", d_kind[i], kin_o[i]);
            chk("R9 open order row", d_row[i], rows[i]);
            chk("R11 done_time", d_time[i], exp_o[i]);
        end

        // ---------- close page ----------
        do_reset(1'b1);
        stream();
        chk("R6 PRE at completion", log_op[4], 1);
        chk("R7 ACT after auto precharge", log_op[6], 2);
        chk("R7 ACT row", log_row[6], 5);
        chk("R7 arrival mid precharge waits", log_op[12], 2);
        chk("R7 no ACT while precharging", log_op[10], 1);
        chk("R7 late arrival waits to 26", log_op[26], 2);
        chk("R9 close count", n_done, 6);
        for (int i = 0; i < 6; i++) begin
            chk("R6 close finish cycle", d_cyc[i], exp_c[i]);
            chk("R6 close kind empty", d_kind[i], 1);
            chk("R9 close order row", d_row[i], rows[i]);
        end

        // ---------- queue overflow, open page ----------
        do_reset(1'b0);
        for (int i = 0; i < 7; i++) arrive(i, i + 1, i);
        run_until(70);
        chk("R10 overflow dropped", n_done, 6);
        for (int i = 0; i < 6; i++) begin
            chk("R10 served row order", d_row[i], i + 1);
            chk("R10 served cycle", d_cyc[i], (i == 0) ? 4 : 4 + 6 * i);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule